// File: doc/BRIEF.md
# PWM Time-Base Counter

The block is the timing backbone of a pulse-width modulator. A prescaler divides the system clock by a configurable ratio. On each prescaled tick, a counter moves according to one of four count modes: up, down, up-down or frozen. The counter width is a parameter, 16 bits by default.

A control word sets the mode, the divide ratio and how new period values take effect. A period value may be written straight into the active period. It may instead be held in a shadow copy that becomes active when the counter next returns to zero.

Downstream logic receives three things:
- the count itself;
- a direction flag for compare logic;
- one-clock pulses that mark the counter landing on zero and landing on the active period.

Counting is started by raising the enable input.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction flag is 1 (up), and both event outputs are 0.
- R2: The counter advances once every D clocks, with D = 2^c * f. The coarse code c is control bits [12:10]. The fine factor f is 1 when control bits [9:7] are 0, and twice that field otherwise.
- R3: With control bits [1:0] = 00 (up), the counter steps by one up to the active period P and then returns to 0. The direction flag is 1.
- R4: With control bits [1:0] = 01 (down), the counter steps down by one and reloads P on the tick after it holds 0. The direction flag is 0.
- R5: With control bits [1:0] = 10 (up-down), the counter climbs to P, turns and descends to 0, then turns again. The direction flag shows the direction of the last step. With P = 3 and D = 1, zero events come 6 clocks apart.
- R6: With control bits [1:0] = 11 (freeze), the count and direction hold, and no events are produced, while enable stays high.
- R7: The zero event and the period event are one-clock pulses. Each is issued together with the count value it reports. When P = 0, both are issued together on every tick.
- R8: Control bit 3 selects how the period loads:
  - At 0, a period write goes to the shadow copy. The shadow copy becomes the active period whenever the counter is set to 0, including at start.
  - At 1, a period write changes the active period at the next clock edge.
- R9: A rising edge of enable sets the count to 0, clears the prescaler phase, and issues a zero event. While enable is low, the count holds and no events are issued.
- R10: In shadow mode, a period write in the same cycle as a shadow-to-active transfer does not reach the active period in that transfer. The transfer takes the shadow content from before the write. The written value becomes active at the following zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable; a rising edge restarts from 0 |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word: mode [1:0], load select [3], fine code [9:7], coarse code [12:10] |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | CW | Period value |
| count | output | CW | Current count |
| count_up | output | 1 | 1 when the last step was upward |
| at_zero | output | 1 | One-clock pulse: count has just become 0 |
| at_period | output | 1 | One-clock pulse: count has just become the active period |

## Verification
The two functions that can fall into the same cycle are the wrap to zero, which moves the shadow period into the active one, and a period write from the register side.

To provoke the collision, the bench watches for the count sitting at its period one clock before the wrap and drives the write on exactly that cycle. It then checks that the next period event still comes at the old value, and that the event after it comes at the written value.

A bench model runs alongside the design and compares count, direction and both events on every clock. This also covers a period of zero, where the zero and period events must coincide.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          per_we,
  input  logic [CW-1:0] per_wdata,
  output logic [CW-1:0] count,
  output logic          count_up,
  output logic          at_zero,
  output logic          at_period
);
  localparam logic [1:0] M_UP = 2'b00, M_DN = 2'b01, M_UD = 2'b10, M_FRZ = 2'b11;
  localparam int PW = 11;

  logic [15:0]   cfg;
  logic [CW-1:0] per_act, per_sh, nxt, per_nxt;
  logic [PW-1:0] pre;
  logic          run_q, nup;

  wire [1:0]    mode     = cfg[1:0];
  wire          imm      = cfg[3];
  wire [2:0]    fine_c   = cfg[9:7];
  wire [2:0]    crs_c    = cfg[12:10];
  wire [3:0]    fine_div = (fine_c == 3'd0) ? 4'd1 : {fine_c, 1'b0};
  wire [PW-1:0] div_m1   = ({{(PW-4){1'b0}}, fine_div} << crs_c) - {{(PW-1){1'b0}}, 1'b1};

  wire start = run_en & ~run_q;
  wire tick  = run_en & run_q & (pre >= div_m1);
  wire load  = start | (tick & (mode != M_FRZ));
  wire hit0  = load & (nxt == '0);

  always_comb begin
    nxt = count;
    nup = count_up;
    if (start) begin
      nxt = '0;
      nup = (mode != M_DN);
    end else begin
      case (mode)
        M_UP: begin
          nxt = (count >= per_act) ? '0 : count + 1'b1;
          nup = 1'b1;
        end
        M_DN: begin
          nxt = (count == '0) ? per_act : count - 1'b1;
          nup = 1'b0;
        end
        M_UD: begin
          if (count_up) begin
            if (count >= per_act) begin
              nup = 1'b0;
              nxt = (count == '0) ? '0 : count - 1'b1;
            end else nxt = count + 1'b1;
          end else if (count == '0) begin
            nup = 1'b1;
            nxt = (per_act == '0) ? '0 : {{(CW-1){1'b0}}, 1'b1};
          end else nxt = count - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    per_nxt = per_act;
    if (hit0 && !imm) per_nxt = per_sh;
    if (per_we && imm) per_nxt = per_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      per_act   <= '0;
      per_sh    <= '0;
      pre       <= '0;
      run_q     <= 1'b0;
      count     <= '0;
      count_up  <= 1'b1;
      at_zero   <= 1'b0;
      at_period <= 1'b0;
    end else begin
      run_q     <= run_en;
      pre       <= (!run_en || start || tick) ? '0 : pre + 1'b1;
      if (cfg_we) cfg <= cfg_wdata;
      if (per_we) per_sh <= per_wdata;
      per_act   <= per_nxt;
      if (load) begin
        count    <= nxt;
        count_up <= nup;
      end
      at_zero   <= hit0;
      at_period <= load & (nxt == per_nxt);
    end
  end

  AST_ZERO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |-> (count == '0)); // R7
  AST_PRD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    at_period |-> (count == per_act)); // R7
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run_en && mode == M_FRZ) |=> ($stable(count) && !at_zero && !at_period)); // R6
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !run_q) |=> (count == '0 && at_zero)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(count) && !at_zero && !at_period)); // R9
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && mode == M_UP && count < per_act) |=> (count == $past(count) + 1'b1)); // R3
  AST_DN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !start && mode == M_DN) |=> !count_up); // R4
endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, cfg_we = 1'b0, per_we = 1'b0;
  logic [15:0] cfg_wdata = '0, per_wdata = '0;
  logic [15:0] count;
  logic count_up, at_zero, at_period;
  int checks = 0, fails = 0;
  bit done = 0;

  pwm_timebase #(.CW(16)) dut (.*);

  always #4 clk = ~clk;

  int m_cnt, m_dir, m_pre, m_prd, m_sh, m_ctrl, m_enq, m_ez, m_ep;
  int mode, k, h, dv, nc, nd, np, ld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 1; m_pre = 0; m_prd = 0; m_sh = 0; m_ctrl = 0;
      m_enq = 0; m_ez = 0; m_ep = 0;
    end else begin
      mode = m_ctrl & 3; k = (m_ctrl >> 10) & 7; h = (m_ctrl >> 7) & 7;
      dv = (1 << k) * ((h == 0) ? 1 : 2 * h);
      nc = m_cnt; nd = m_dir; np = m_prd; ld = 0;
      if (run_en && !m_enq) begin
        nc = 0; nd = (mode != 1); ld = 1; m_pre = 0;
      end else if (run_en) begin
        if (m_pre >= dv - 1) begin
          m_pre = 0;
          if (mode != 3) begin
            ld = 1;
            if (mode == 0) begin nc = (m_cnt >= m_prd) ? 0 : m_cnt + 1; nd = 1; end
            else if (mode == 1) begin nc = (m_cnt == 0) ? m_prd : m_cnt - 1; nd = 0; end
            else if (m_dir == 1) begin
              if (m_cnt >= m_prd) begin nd = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
              else nc = m_cnt + 1;
            end else if (m_cnt == 0) begin nd = 1; nc = (m_prd == 0) ? 0 : 1; end
            else nc = m_cnt - 1;
          end
        end else m_pre++;
      end else m_pre = 0;
      if (ld && nc == 0 && (m_ctrl & 8) == 0) np = m_sh;
      if (per_we) begin m_sh = per_wdata; if (m_ctrl & 8) np = per_wdata; end
      m_ez = (ld && nc == 0); m_ep = (ld && nc == np);
      m_cnt = nc; m_dir = nd; m_prd = np; m_enq = run_en;
      if (cfg_we) m_ctrl = cfg_wdata;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      case (m_ctrl & 3)
        0: tag = "R3"; 1: tag = "R4"; 2: tag = "R5"; default: tag = "R6";
      endcase
      chk({tag, " count"}, count, m_cnt);
      chk({tag, " count_up"}, count_up, m_dir);
      chk("R7 at_zero", at_zero, m_ez);
      chk("R7 at_period", at_period, m_ep);
    end
  end

  task automatic wr_cfg(int v);
    cfg_wdata = v[15:0]; cfg_we = 1; @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_per(int v);
    per_wdata = v[15:0]; per_we = 1; @(negedge clk); per_we = 0;
  endtask
  task automatic restart();
    run_en = 0; @(negedge clk); run_en = 1; @(negedge clk);
  endtask
  task automatic wait_ev(bit prd);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (prd ? at_period : at_zero) return;
    end
    chk("event timeout", 0, 1);
  endtask
  task automatic wait_cnt(int v);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (count == v[15:0]) return;
    end
    chk("count timeout", 0, 1);
  endtask

  initial begin
    int n, held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 count_up", count_up, 1);
    chk("R1 events", {at_zero, at_period}, 0);

    wr_cfg('h0008); wr_per(4); restart();
    wait_ev(1); chk("R3 period value", count, 4);
    wait_ev(0); chk("R3 wrap", count, 0);

    wr_cfg('h0008 | (1 << 10) | (3 << 7)); wr_per(5); restart();
    wait_ev(0); n = 0;
    do begin @(negedge clk); n++; end while (!at_zero && n < 1000);
    chk("R2 zero spacing", n, 72);

    run_en = 0; @(negedge clk); held = count;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R9 idle hold", count, held);
      chk("R9 idle no event", {at_zero, at_period}, 0);
    end
    run_en = 1; @(negedge clk); @(negedge clk);
    chk("R9 start at zero", count, 0);

    wr_cfg('h0009); wr_per(5); restart();
    wait_ev(1); chk("R4 reload", count, 5); chk("R4 dir", count_up, 0);

    wr_cfg('h000A); wr_per(3); restart();
    wait_ev(1); @(negedge clk);
    chk("R5 turn", count, 2); chk("R5 dir down", count_up, 0);
    wait_ev(0); n = 0;
    do begin @(negedge clk); n++; end while (!at_zero && n < 1000);
    chk("R5 zero spacing", n, 6);

    wr_cfg('h000B); @(negedge clk); held = count;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R6 freeze hold", count, held);
      chk("R6 no event", {at_zero, at_period}, 0);
    end

    wr_cfg('h0008); wr_per(0); restart();
    @(negedge clk); chk("R7 both events", {at_zero, at_period}, 3);

    wr_per(3); restart(); wait_cnt(1);
    per_wdata = 8; per_we = 1; @(negedge clk); per_we = 0;
    wait_ev(1); chk("R8 immediate", count, 8);

    wr_cfg('h0000); wait_ev(0); wr_per(3);
    wait_ev(0); wait_cnt(1); wr_per(6);
    wait_ev(1); chk("R8 shadow keeps old", count, 3);
    wait_ev(1); chk("R8 shadow applied", count, 6);

    wr_per(3); wait_ev(0); wait_ev(0);
    wait_cnt(3);
    per_wdata = 9; per_we = 1; @(negedge clk); per_we = 0;
    wait_ev(1); chk("R10 coincident old", count, 3);
    wait_ev(1); chk("R10 coincident new", count, 9);

    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule